// File: doc/BRIEF.md
# I2C Master Receive Byte Path

This block is the receive side of an I2C bus master once the address phase is done. It collects serial data bits into a shift register, most significant bit first. After each byte's acknowledge slot it moves the byte into a data register that software reads. It decides what the receiver drives in each acknowledge slot, and it issues the closing STOP or repeated START once the last byte has been acknowledged.

The data register and the shift register form a two-entry buffer. When a byte completes while the data register still holds an unread byte, the block raises a both-full flag and holds SCL low. No further bits are taken until software reads the data register. While the bus is held, software has time to clear the acknowledge enable or request the end condition, so that the final bytes are answered correctly.

A defer control moves the acknowledge decision one byte later, which is what a two-byte read needs. A clock-phase controller outside this block supplies one bit strobe per sampled bit, with the strobe that follows the eighth data bit marking the acknowledge slot. It also supplies a start strobe when the address phase ends.

Top module: `i2c_rx_bytepath`

## Requirements
- R1: After reset, the ready flag, the both-full flag, the SCL hold, the acknowledge enable, the defer control, both pending requests, the busy flag and the SDA pull-down are all 0, and the data register reads 0.
- R2: Once started, the block shifts in 8 sampled bits MSB first. The ninth strobe ends the acknowledge slot. If the data register holds no unread byte at that point, the new byte is copied into it and the ready flag becomes 1.
- R3: A data read while ready is 1 and both-full is 0 returns the stored byte and clears ready.
- R4: A byte that completes while ready is 1 leaves the byte in the shift register and sets both-full and the SCL hold. Bit strobes are then ignored until a data read.
- R5: A data read while both-full is 1 returns the older byte, moves the held byte into the data register and clears both-full. Ready stays 1.
- R6: A data read while ready is 0 returns the last byte again and changes no flag.
- R7: With defer at 0, the SDA pull-down during the acknowledge slot equals the live acknowledge enable: 1 (SDA low) means ACK and 0 (released) means NACK.
- R8: With defer at 1, a byte is answered with the acknowledge enable value captured at the end of the previous byte's acknowledge slot. The first byte after a start strobe is always acknowledged.
- R9: A pending STOP or START is issued only when no byte is in progress and at least one byte has ended since the start strobe. It is never issued before the current byte's acknowledge slot ends. Issuing it produces a one-cycle pulse, clears both pending requests and drops busy.
- R10: If STOP and START are both pending, only the STOP pulse is produced. A lone START request produces the START pulse.
- R11: For a single-byte read, where acknowledge is cleared and STOP is requested before the byte, the byte is answered with NACK and the STOP pulse follows its acknowledge slot.
- R12: In a read of three or more bytes, clearing the acknowledge enable while both-full is set, before reading the third-from-last byte, makes the last byte receive NACK while earlier bytes receive ACK.
- R13: While busy is 0, bit strobes change neither the flags nor the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Data register read strobe |
| rdata_o | output | 8 | Data register contents |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_ack_i | input | 1 | Acknowledge enable value written |
| ctl_defer_i | input | 1 | Defer control value written |
| ctl_stop_i | input | 1 | STOP request value written |
| ctl_start_i | input | 1 | Repeated START request value written |
| rdy_o | output | 1 | Data register holds an unread byte |
| both_full_o | output | 1 | Shift and data registers both hold unread bytes |
| ack_en_o | output | 1 | Current acknowledge enable |
| defer_o | output | 1 | Current defer control |
| stop_pend_o | output | 1 | STOP request pending |
| start_pend_o | output | 1 | START request pending |
| rx_begin_i | input | 1 | Address phase done, receive begins |
| bit_tick_i | input | 1 | One strobe per sampled bit or acknowledge slot |
| sda_i | input | 1 | Sampled SDA level |
| sda_pull_o | output | 1 | Pull SDA low in this acknowledge slot |
| scl_hold_o | output | 1 | Hold SCL low |
| stop_go_o | output | 1 | Issue STOP condition now |
| start_go_o | output | 1 | Issue repeated START condition now |
| busy_o | output | 1 | Receive in progress |

## Verification
On every cycle, the assertions check that both-full never appears without ready and that the shift register stays frozen while the bus is held. They also check that an empty read leaves data and flags untouched, that a both-full read leaves exactly one byte unread, that the acknowledge drive appears only in the acknowledge slot, and that at most one end condition fires and clears its request. The bench scenarios show the byte-level properties no single-cycle property can express: the MSB-first byte value, the deferred acknowledge across a two-byte read, the NACK landing on the last byte of longer reads, and the end condition following the final acknowledge slot.

// File: rtl/i2crx_pkg.sv
package i2crx_pkg;

  // Acknowledge chosen for the byte in the shift register.
  function automatic logic ack_choice(input logic defer, input logic live, input logic held);
    return defer ? held : live;
  endfunction

  // End condition pulses {stop, start}; STOP outranks START.
  function automatic logic [1:0] cond_pick(input logic go, input logic stop_p, input logic start_p);
    logic [1:0] r;
    r[1] = go & stop_p;
    r[0] = go & ~stop_p & start_p;
    return r;
  endfunction

endpackage

// File: rtl/i2crx_shifter.sv
module i2crx_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          begin_i,
  input  logic          tick_i,
  input  logic          sda_i,
  output logic [DW-1:0] sr_o,
  output logic          slot_o,
  output logic          ack_tick_o,
  output logic          idle_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] SLOT = CW'(DW);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sr_q;

  assign slot_o     = (cnt_q == SLOT);
  assign ack_tick_o = tick_i & slot_o;
  assign idle_o     = (cnt_q == '0);
  assign sr_o       = sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (begin_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (slot_o) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        sr_q  <= {sr_q[DW-2:0], sda_i};
      end
    end
  end

  // R7: the acknowledge slot lasts until its strobe arrives
  assert_slot_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_o && !tick_i && !begin_i) |=> slot_o);

endmodule

// File: rtl/i2crx_ackpos.sv
module i2crx_ackpos
  import i2crx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic begin_i,
  input  logic ack_tick_i,
  input  logic slot_i,
  input  logic active_i,
  input  logic defer_i,
  input  logic ack_en_i,
  output logic sda_pull_o
);
  logic held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          held_q <= 1'b1;
    else if (begin_i)    held_q <= 1'b1;
    else if (ack_tick_i) held_q <= ack_en_i;
  end

  assign sda_pull_o = active_i & slot_i & ack_choice(defer_i, ack_en_i, held_q);

  // R7, R8: SDA is only ever pulled inside an acknowledge slot of a live receive
  assert_pull_in_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> (slot_i && active_i));

endmodule

// File: rtl/i2crx_buf.sv
module i2crx_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_tick_i,
  input  logic          rd_i,
  input  logic [DW-1:0] sr_i,
  output logic [DW-1:0] dr_o,
  output logic          rdy_o,
  output logic          full2_o
);
  logic [DW-1:0] dr_q;
  logic          rdy_q, full2_q;
  logic          rd_hit;

  assign rd_hit  = rd_i & rdy_q;
  assign dr_o    = dr_q;
  assign rdy_o   = rdy_q;
  assign full2_o = full2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q    <= '0;
      rdy_q   <= 1'b0;
      full2_q <= 1'b0;
    end else if (ack_tick_i) begin
      if (!rdy_q || rd_hit) begin
        dr_q  <= sr_i;
        rdy_q <= 1'b1;
      end else begin
        full2_q <= 1'b1;
      end
    end else if (rd_hit) begin
      if (full2_q) begin
        dr_q    <= sr_i;
        full2_q <= 1'b0;
      end else begin
        rdy_q <= 1'b0;
      end
    end
  end

  // R4: both-full never exists without an unread data byte
  assert_full_needs_rdy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full2_q |-> rdy_q);

  // R6: an empty read leaves data and flags alone
  assert_empty_read_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !rdy_q && !ack_tick_i) |=> ($stable(dr_q) && !rdy_q && !full2_q));

  // R5: reading while both-full leaves exactly one unread byte
  assert_full_read_one_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && full2_q) |=> (rdy_q && !full2_q));

endmodule

// File: rtl/i2c_rx_bytepath.sv
module i2c_rx_bytepath
  import i2crx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  input  logic          ctl_we_i,
  input  logic          ctl_ack_i,
  input  logic          ctl_defer_i,
  input  logic          ctl_stop_i,
  input  logic          ctl_start_i,
  output logic          rdy_o,
  output logic          both_full_o,
  output logic          ack_en_o,
  output logic          defer_o,
  output logic          stop_pend_o,
  output logic          start_pend_o,
  input  logic          rx_begin_i,
  input  logic          bit_tick_i,
  input  logic          sda_i,
  output logic          sda_pull_o,
  output logic          scl_hold_o,
  output logic          stop_go_o,
  output logic          start_go_o,
  output logic          busy_o
);
  logic          ack_en_q, defer_q, stop_q, start_q;
  logic          active_q, seen_q;
  logic          full2, slot, ack_tick, idle, issue, tick_ok;
  logic [DW-1:0] sr;
  logic [1:0]    go;

  // Named internal events
  assign issue   = active_q & seen_q & idle & (stop_q | start_q);
  assign tick_ok = bit_tick_i & active_q & ~full2 & ~issue;
  assign go      = cond_pick(issue, stop_q, start_q);

  i2crx_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .begin_i(rx_begin_i), .tick_i(tick_ok),
    .sda_i(sda_i), .sr_o(sr), .slot_o(slot), .ack_tick_o(ack_tick), .idle_o(idle)
  );

  i2crx_ackpos u_ack (
    .clk(clk), .rst_n(rst_n), .begin_i(rx_begin_i), .ack_tick_i(ack_tick),
    .slot_i(slot), .active_i(active_q), .defer_i(defer_q), .ack_en_i(ack_en_q),
    .sda_pull_o(sda_pull_o)
  );

  i2crx_buf #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .ack_tick_i(ack_tick), .rd_i(rd_i), .sr_i(sr),
    .dr_o(rdata_o), .rdy_o(rdy_o), .full2_o(full2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_en_q <= 1'b0;
      defer_q  <= 1'b0;
      stop_q   <= 1'b0;
      start_q  <= 1'b0;
    end else if (ctl_we_i) begin
      ack_en_q <= ctl_ack_i;
      defer_q  <= ctl_defer_i;
      stop_q   <= ctl_stop_i;
      start_q  <= ctl_start_i;
    end else if (issue) begin
      stop_q  <= 1'b0;
      start_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      seen_q   <= 1'b0;
    end else if (rx_begin_i) begin
      active_q <= 1'b1;
      seen_q   <= 1'b0;
    end else begin
      if (issue)    active_q <= 1'b0;
      if (ack_tick) seen_q   <= 1'b1;
    end
  end

  assign both_full_o  = full2;
  assign scl_hold_o   = full2;
  assign ack_en_o     = ack_en_q;
  assign defer_o      = defer_q;
  assign stop_pend_o  = stop_q;
  assign start_pend_o = start_q;
  assign stop_go_o    = go[1];
  assign start_go_o   = go[0];
  assign busy_o       = active_q;

  // R10: never both end conditions at once
  assert_one_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stop_go_o, start_go_o}));

  // R9: an issued condition clears its request and ends the receive
  assert_issue_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((stop_go_o || start_go_o) && !ctl_we_i && !rx_begin_i) |=> (!stop_q && !start_q && !active_q));

  // R4: the shift register is frozen while the bus is held
  assert_hold_freezes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full2 |=> $stable(sr));

endmodule

// File: tb/i2c_rx_bytepath_tb.sv
module i2c_rx_bytepath_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_i = 0, ctl_we_i = 0, ctl_ack_i = 0, ctl_defer_i = 0, ctl_stop_i = 0, ctl_start_i = 0;
  logic       rx_begin_i = 0, bit_tick_i = 0, sda_i = 0;
  logic [7:0] rdata_o;
  logic       rdy_o, both_full_o, ack_en_o, defer_o, stop_pend_o, start_pend_o;
  logic       sda_pull_o, scl_hold_o, stop_go_o, start_go_o, busy_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_rx_bytepath u_dut (
    .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .rdata_o(rdata_o),
    .ctl_we_i(ctl_we_i), .ctl_ack_i(ctl_ack_i), .ctl_defer_i(ctl_defer_i),
    .ctl_stop_i(ctl_stop_i), .ctl_start_i(ctl_start_i),
    .rdy_o(rdy_o), .both_full_o(both_full_o), .ack_en_o(ack_en_o), .defer_o(defer_o),
    .stop_pend_o(stop_pend_o), .start_pend_o(start_pend_o),
    .rx_begin_i(rx_begin_i), .bit_tick_i(bit_tick_i), .sda_i(sda_i),
    .sda_pull_o(sda_pull_o), .scl_hold_o(scl_hold_o), .stop_go_o(stop_go_o),
    .start_go_o(start_go_o), .busy_o(busy_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic b);
    @(negedge clk); bit_tick_i = 1'b1; sda_i = b;
    @(negedge clk); bit_tick_i = 1'b0;
  endtask

  task automatic begin_rx();
    @(negedge clk); rx_begin_i = 1'b1;
    @(negedge clk); rx_begin_i = 1'b0;
  endtask

  task automatic ctl(input logic a, input logic d, input logic sp, input logic st);
    @(negedge clk); ctl_we_i = 1; ctl_ack_i = a; ctl_defer_i = d; ctl_stop_i = sp; ctl_start_i = st;
    @(negedge clk); ctl_we_i = 0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); rd_i = 1'b1; v = rdata_o;
    @(negedge clk); rd_i = 1'b0;
  endtask

  // 8 data bits MSB first, check acknowledge drive in the slot, then the slot strobe
  task automatic byte_in(input logic [7:0] b, input logic exp_pull, input string tag);
    for (int i = 7; i >= 0; i--) tick(b[i]);
    check({tag, " ack drive"}, {7'd0, sda_pull_o}, {7'd0, exp_pull});
    check("R9 no condition before slot ends", {6'd0, stop_go_o, start_go_o}, 8'd0);
    tick(1'b1);
  endtask

  task automatic t_reset();
    check("R1 rdy", {7'd0, rdy_o}, 0);
    check("R1 both_full/hold", {6'd0, both_full_o, scl_hold_o}, 0);
    check("R1 ctl", {4'd0, ack_en_o, defer_o, stop_pend_o, start_pend_o}, 0);
    check("R1 bus", {5'd0, sda_pull_o, busy_o, stop_go_o}, 0);
    check("R1 data", rdata_o, 8'h00);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 9; i++) tick(1'b1);
    check("R13 idle rdy", {7'd0, rdy_o}, 0);
    check("R13 idle data", rdata_o, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] v;
    begin_rx();
    ctl(1, 0, 0, 0);
    byte_in(8'hA5, 1'b1, "R7 live ACK");
    check("R2 rdy set", {7'd0, rdy_o}, 1);
    rd(v);
    check("R3 read value", v, 8'hA5);
    check("R3 rdy cleared", {7'd0, rdy_o}, 0);
    rd(v);
    check("R6 empty read value", v, 8'hA5);
    check("R6 empty read flags", {6'd0, rdy_o, both_full_o}, 0);
  endtask

  task automatic t_stall();
    logic [7:0] v;
    byte_in(8'h3C, 1'b1, "R7 ACK byte1");
    byte_in(8'hC3, 1'b1, "R7 ACK byte2");
    check("R4 both_full+hold", {6'd0, both_full_o, scl_hold_o}, 8'h03);
    for (int i = 0; i < 3; i++) tick(1'b1);
    check("R4 still held", {6'd0, rdy_o, both_full_o}, 8'h03);
    rd(v);
    check("R5 older byte", v, 8'h3C);
    check("R5 flags after", {6'd0, rdy_o, both_full_o}, 8'h02);
    rd(v);
    check("R4 held byte intact", v, 8'hC3);
  endtask

  task automatic t_two_byte();
    logic [7:0] v;
    begin_rx();
    ctl(0, 1, 0, 0);
    byte_in(8'h5A, 1'b1, "R8 first byte ACK");
    byte_in(8'h96, 1'b0, "R8 second byte NACK");
    check("R4 both_full", {7'd0, both_full_o}, 1);
    ctl(0, 1, 1, 0);
    check("R9 stop pulse", {6'd0, stop_go_o, start_go_o}, 8'h02);
    @(negedge clk);
    check("R9 after pulse", {5'd0, stop_go_o, stop_pend_o, busy_o}, 0);
    rd(v); check("R5 two-byte first", v, 8'h5A);
    rd(v); check("R5 two-byte second", v, 8'h96);
  endtask

  task automatic t_single();
    logic [7:0] v;
    begin_rx();
    ctl(0, 0, 1, 0);
    byte_in(8'hE1, 1'b0, "R11 single NACK");
    check("R11 stop after byte", {7'd0, stop_go_o}, 1);
    @(negedge clk);
    check("R11 ended", {6'd0, busy_o, stop_pend_o}, 0);
    for (int i = 0; i < 9; i++) tick(1'b0);
    check("R13 ignored after end", {6'd0, rdy_o, both_full_o}, 8'h02);
    rd(v); check("R11 byte", v, 8'hE1);
  endtask

  task automatic t_three();
    logic [7:0] v;
    begin_rx();
    ctl(1, 0, 0, 0);
    byte_in(8'h11, 1'b1, "R12 byte1 ACK");
    byte_in(8'h22, 1'b1, "R12 byte2 ACK");
    ctl(0, 0, 0, 0);
    rd(v); check("R12 byte1", v, 8'h11);
    byte_in(8'h33, 1'b0, "R12 last NACK");
    ctl(0, 0, 0, 1);
    check("R10 start pulse", {6'd0, stop_go_o, start_go_o}, 8'h01);
    rd(v); check("R12 byte2", v, 8'h22);
    rd(v); check("R12 byte3", v, 8'h33);
    check("R3 drained", {7'd0, rdy_o}, 0);
  endtask

  task automatic t_prio();
    logic [7:0] v;
    begin_rx();
    ctl(1, 0, 0, 0);
    byte_in(8'h44, 1'b1, "R7 ACK");
    ctl(1, 0, 1, 1);
    check("R10 stop wins", {6'd0, stop_go_o, start_go_o}, 8'h02);
    @(negedge clk);
    check("R10 both cleared", {6'd0, stop_pend_o, start_pend_o}, 0);
    rd(v); check("R2 value", v, 8'h44);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_basic();
    t_stall();
    t_two_byte();
    t_single();
    t_three();
    t_prio();
    finish_run();
  end
endmodule